// File: doc/BRIEF.md
# Latchable 64-bit Time Counter

A free-running 64-bit counter advances by one on every clock. Software cannot read it directly. Instead it asks for a snapshot by writing a latch request to a control register. That request copies the live count into a pair of 32-bit words: the low word and the high word. Software then reads the two words at its own pace and gets a coherent 64-bit value, even though the counter keeps running.

A clear request zeroes the live counter and both snapshot words. Both request bits act in the cycle of the write and read back as zero afterwards. If one write sets both bits, the latch is applied first and the clear second, so the words end up at zero.

The two snapshot words can also be written directly, for example to preload a known value. Access is through a simple single-cycle register bus. Writes take effect on the clock edge and reads are combinational.

Top module: `time_snap_counter`

## Requirements
- R1: The control register is at offset 0xA0, the low snapshot word (count bits 31..0) is at 0xA4 and the high snapshot word (count bits 63..32) is at 0xA8. A read of any other offset returns zero.
- R2: After reset, the live counter increases by exactly one on every rising clock edge, unless a clear request is being serviced on that edge.
- R3: Writing the control register with bit 1 (latch) set loads both snapshot words with the live count held just before that write's clock edge.
- R4: Writing the control register with bit 0 (clear) set zeroes both snapshot words and the live counter. The counter reads 0 for one cycle and then resumes counting from there.
- R5: A single control write with both bits 1 and 0 set leaves both snapshot words at zero and the live counter at zero.
- R6: The request bits 1 and 0 of the control register always read back as 0. The other 30 control bits read back what was last written to them.
- R7: A bus write to 0xA4 or 0xA8 replaces only that snapshot word and does not disturb the live counter.
- R8: While rst_n is low, the control register and both snapshot words read zero. After rst_n rises, the counter stays at zero through two rising edges, takes the value 1 on the third, and keeps counting from there.
- R9: A bus write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The bench tests the latch alone, the clear alone, both bits in one write, and the clear followed by a latch. The combined write shows whether the latch is ordered before the clear. The clear-then-latch sequence shows whether the live counter, and not only the snapshot words, was zeroed. Two latches a known number of cycles apart check the count step without depending on an absolute value. Direct word writes and writes to an unmapped offset, each followed by reads of every register, show whether a write stays within its own target. A long random mix of writes is then compared against the reference model on every cycle.

// File: rtl/tctr_pkg.sv
package tctr_pkg;
  localparam int unsigned REQ_CLR_BIT = 0;
  localparam int unsigned REQ_LAT_BIT = 1;

  typedef struct packed {
    logic latch;
    logic clear;
  } tctr_req_t;
endpackage

// File: rtl/tctr_rst_sync.sv
module tctr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tctr_live_count.sv
module tctr_live_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_clear_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tctr_reg_decode.sv
module tctr_reg_decode
  import tctr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned OFF_CTRL  = 'hA0,
  parameter int unsigned OFF_WORD0 = 'hA4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_WORDS*DATA_W-1:0]   words_i,
  output tctr_req_t                     req_o,
  output logic [NUM_WORDS-1:0]          word_we_o,
  output logic [DATA_W-1:0]             ctrl_o,
  output logic [DATA_W-1:0]             rdata_o
);
  localparam logic [DATA_W-1:0] REQ_MASK =
    (DATA_W'(1) << REQ_CLR_BIT) | (DATA_W'(1) << REQ_LAT_BIT);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OFF_CTRL);

  logic                 ctrl_hit;
  logic                 ctrl_we;
  logic [NUM_WORDS-1:0] word_hit;
  logic [DATA_W-1:0]    ctrl_q;
  logic [DATA_W-1:0]    ctrl_d;

  assign ctrl_hit = (addr_i == CTRL_ADDR);
  assign ctrl_we  = wr_i && ctrl_hit;

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word_hit
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(OFF_WORD0 + 4 * gi);
    assign word_hit[gi]  = (addr_i == WORD_ADDR);
    assign word_we_o[gi] = wr_i && word_hit[gi];
  end

  // Requests act in the write cycle; the stored copy keeps them cleared.
  always_comb begin
    req_o.latch = ctrl_we && wdata_i[REQ_LAT_BIT];
    req_o.clear = ctrl_we && wdata_i[REQ_CLR_BIT];
    ctrl_d      = ctrl_we ? (wdata_i & ~REQ_MASK) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) rdata_o = ctrl_q;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (word_hit[i]) rdata_o = words_i[i*DATA_W +: DATA_W];
    end
  end

  assert_req_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_o[REQ_LAT_BIT] == 1'b0) && (ctrl_o[REQ_CLR_BIT] == 1'b0)
                && ((ctrl_o | REQ_MASK) == ($past(wdata_i) | REQ_MASK)));
endmodule

// File: rtl/tctr_snapshot.sv
module tctr_snapshot
  import tctr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS*DATA_W-1:0] cnt_i,
  input  tctr_req_t                   req_i,
  input  logic [NUM_WORDS-1:0]        word_we_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);
  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;
    logic              word_en;

    // Latch is applied before clear, so clear wins when both are set.
    always_comb begin
      word_en = word_we_i[gi] || req_i.latch || req_i.clear;
      word_d  = word_q;
      if (word_we_i[gi]) word_d = wdata_i;
      if (req_i.latch)   word_d = cnt_i[gi*DATA_W +: DATA_W];
      if (req_i.clear)   word_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign words_o[gi*DATA_W +: DATA_W] = word_q;

    assert_latch_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i.latch && !req_i.clear) |=> word_q == $past(cnt_i[gi*DATA_W +: DATA_W]));
    assert_both_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_i.clear |=> word_q == '0);
    assert_direct_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_we_i[gi] && !req_i.latch && !req_i.clear) |=> word_q == $past(wdata_i));
  end
endmodule

// File: rtl/time_snap_counter.sv
module time_snap_counter
  import tctr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned OFF_CTRL  = 'hA0,
  parameter int unsigned OFF_WORD0 = 'hA4,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned CNT_W = NUM_WORDS * DATA_W;

  logic                 rst_sync_n;
  tctr_req_t            req;
  logic [NUM_WORDS-1:0] word_we;
  logic [DATA_W-1:0]    ctrl_val;
  logic [CNT_W-1:0]     live_cnt;
  logic [CNT_W-1:0]     words;

  tctr_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  tctr_live_count #(.CNT_W(CNT_W)) u_live_count (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (req.clear),
    .cnt_o (live_cnt)
  );

  tctr_reg_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS),
    .OFF_CTRL  (OFF_CTRL),
    .OFF_WORD0 (OFF_WORD0)
  ) u_reg_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .words_i   (words),
    .req_o     (req),
    .word_we_o (word_we),
    .ctrl_o    (ctrl_val),
    .rdata_o   (bus_rdata)
  );

  tctr_snapshot #(
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_snapshot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnt_i     (live_cnt),
    .req_i     (req),
    .word_we_i (word_we),
    .wdata_i   (bus_wdata),
    .words_o   (words)
  );

  logic addr_mapped;
  always_comb begin
    addr_mapped = (bus_addr == ADDR_W'(OFF_CTRL));
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (bus_addr == ADDR_W'(OFF_WORD0 + 4 * i)) addr_mapped = 1'b1;
    end
  end

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && !addr_mapped) |=> $stable(words) && $stable(ctrl_val));
  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({word_we, req.latch || req.clear}));
endmodule

// File: tb/time_snap_counter_bench.sv
module time_snap_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'hA0;
  localparam logic [7:0] A_LO   = 8'hA4;
  localparam logic [7:0] A_HI   = 8'hA8;
  localparam logic [7:0] A_NONE = 8'hAC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_errors = 0;
  int cyc_cnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  time_snap_counter u_time_snap_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  // Behavioural reference model
  bit          m_s1, m_s2;
  logic [63:0] m_cnt;
  logic [31:0] m_lo, m_hi, m_ctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cnt = '0; m_lo = '0; m_hi = '0; m_ctl = '0;
    end else if (!m_s2) begin
      m_s2 = m_s1; m_s1 = 1;
    end else begin
      logic [63:0] nc;
      nc = m_cnt + 64'd1;
      if (bus_wr) begin
        if (bus_addr == A_CTRL) begin
          if (bus_wdata[1]) begin m_lo = m_cnt[31:0]; m_hi = m_cnt[63:32]; end
          if (bus_wdata[0]) begin m_lo = '0; m_hi = '0; nc = '0; end
          m_ctl = bus_wdata & 32'hFFFF_FFFC;
        end else if (bus_addr == A_LO) m_lo = bus_wdata;
        else if (bus_addr == A_HI) m_hi = bus_wdata;
      end
      m_cnt = nc;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == A_CTRL) return m_ctl;
    if (a == A_LO)   return m_lo;
    if (a == A_HI)   return m_hi;
    return '0;
  endfunction

  function automatic void finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (bus_addr == A_CTRL)                      chk("R6 model ctrl", bus_rdata, m_read(bus_addr));
    else if (bus_addr == A_LO || bus_addr == A_HI) chk("R3 model word", bus_rdata, m_read(bus_addr));
    else                                         chk("R1 model other", bus_rdata, m_read(bus_addr));
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog R2: got timeout expected end of run");
      finish_run();
      $finish;
    end
  end

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rdv(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #3 v = bus_rdata;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rdv(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(negedge clk);
    // R8: reset values
    rd("R8 ctrl in reset", A_CTRL, 32'h0);
    rd("R8 low in reset", A_LO, 32'h0);
    rd("R8 high in reset", A_HI, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_wr = 1'b0; bus_addr = A_NONE;
    // R8: latch sampled on the fifth edge after release captures 2
    repeat (3) cyc(1'b0, A_NONE, '0);
    cyc(1'b1, A_CTRL, 32'h2);
    rd("R8 count start", A_LO, 32'd2);
    rd("R1 high word at small count", A_HI, 32'h0);

    // R2: two latches seven edges apart
    cyc(1'b1, A_CTRL, 32'h2);
    rdv(A_LO, v1);
    repeat (5) cyc(1'b0, A_NONE, '0);
    cyc(1'b1, A_CTRL, 32'h2);
    rdv(A_LO, v2);
    chk("R2 step between latches", v2 - v1, 32'd7);
    rd("R6 latch bit reads zero", A_CTRL, 32'h0);

    // R4: clear alone then latch
    cyc(1'b1, A_CTRL, 32'h1);
    rd("R4 low after clear", A_LO, 32'h0);
    rd("R4 high after clear", A_HI, 32'h0);
    cyc(1'b1, A_CTRL, 32'h2);
    rd("R4 counter restarted", A_LO, 32'd2);

    // R5: both bits, with preloaded words
    cyc(1'b1, A_HI, 32'hDEAD_BEEF);
    cyc(1'b1, A_LO, 32'h0BAD_F00D);
    cyc(1'b1, A_CTRL, 32'h3);
    rd("R5 low zero", A_LO, 32'h0);
    rd("R5 high zero", A_HI, 32'h0);
    cyc(1'b1, A_CTRL, 32'h2);
    rd("R5 counter zeroed", A_LO, 32'd2);

    // R6: other control bits kept, request bits cleared
    cyc(1'b1, A_CTRL, 32'hF0F0_00A6);
    rd("R6 ctrl readback", A_CTRL, 32'hF0F0_00A4);

    // R7: direct word writes
    cyc(1'b1, A_LO, 32'h1234_5678);
    rd("R7 low written", A_LO, 32'h1234_5678);
    rd("R7 high untouched", A_HI, 32'h0);
    cyc(1'b1, A_HI, 32'hCAFE_0001);
    rd("R7 high written", A_HI, 32'hCAFE_0001);
    rd("R7 low kept", A_LO, 32'h1234_5678);

    // R9: unmapped writes
    cyc(1'b1, A_NONE, 32'hFFFF_FFFF);
    cyc(1'b1, 8'h00, 32'hFFFF_FFFF);
    cyc(1'b1, 8'hA2, 32'hFFFF_FFFF);
    rd("R9 ctrl kept", A_CTRL, 32'hF0F0_00A4);
    rd("R9 low kept", A_LO, 32'h1234_5678);
    rd("R9 high kept", A_HI, 32'hCAFE_0001);
    rd("R1 unmapped reads zero", A_NONE, 32'h0);

    // R3: random traffic, compared to the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r, d;
      logic [7:0]  a;
      r = $urandom;
      case (r[1:0])
        2'd0: a = A_CTRL;
        2'd1: a = A_LO;
        2'd2: a = A_HI;
        default: a = A_NONE;
      endcase
      d = $urandom;
      if (a == A_CTRL) d[0] = (r[9:4] == 6'd0);
      cyc(r[2], a, d);
    end
    cyc(1'b0, A_NONE, '0);
    repeat (2) @(negedge clk);
    finish_run();
    $finish;
  end
endmodule